// File: doc/BRIEF.md
# Track Format Byte Engine

This block produces the byte stream for formatting one track of a double-density disk. The host loads bytes into a one-byte holding register, and the engine requests each new byte through a data-request flag. On each byte slot the engine turns the held value into an output byte. The output byte carries a tag that marks it as plain data, a missing-clock address mark or a checksum byte. A serialiser downstream adds the clock bits and writes the bits to the medium.

A small set of host values acts as in-band commands. One value presets the running checksum and emits a sync mark. A second value emits a second mark pattern. A third value emits the two checksum bytes. The operation runs from one index pulse to the next. If the host has not supplied a byte when a slot comes due, a zero byte takes its place. The operation ends with an interrupt. It ends early if no byte was loaded before the first index pulse.

Top module: `trackfmt_engine`

## Requirements
- R1: After reset, busy, drq, wgate, intrq, lost_data and out_valid are all low.
- R2: A cmd_start pulse while idle sets busy and drq and clears lost_data and intrq in the next cycle. A cmd_start pulse while busy has no effect.
- R3: A host_wr pulse fills the holding register, so drq drops. Byte slots that come before writing begins produce no output.
- R4: If the holding register is still empty at the first index rising edge, the operation ends. busy clears, lost_data and intrq set, and no byte is emitted.
- R5: If the register is full at the first index rising edge, writing begins. wgate stays low until the first byte slot. It rises in the same cycle as the first out_valid pulse.
- R6: While writing, each byte_tick pulse gives one out_valid pulse in the next cycle. A held value that is not F5, F6 or F7 (hex) is emitted unchanged with tag 0 (data) and folded into the checksum.
- R7: A held F5 presets the checksum to FFFF and then emits A1 with tag 1 (mark). The A1 is folded into the checksum.
- R8: A held F6 emits C2 with tag 1 (mark), folded into the checksum.
- R9: A held F7 emits the checksum high byte with tag 2 (crc). The next slot emits the low byte with tag 2 without taking a new host byte. Neither byte changes the checksum. The checksum is CRC-16 with polynomial 1021 (hex), shifted most significant bit first.
- R10: A slot that finds the register empty emits 00 with tag 0, folds 00 into the checksum, sets lost_data and continues writing.
- R11: While writing, an index rising edge ends the operation. busy, wgate and drq fall and intrq sets. A byte_tick in the same cycle as that edge emits nothing.
- R12: Each slot that takes the held byte sets drq again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Starts a format operation (one-cycle pulse) |
| host_wr | input | 1 | Host loads host_data into the holding register |
| host_data | input | 8 | Host byte |
| byte_tick | input | 1 | One pulse per byte slot |
| index_in | input | 1 | Index sensor level, acted on at its rising edge |
| out_valid | output | 1 | One-cycle strobe for an output byte |
| out_byte | output | 8 | Output byte value |
| out_tag | output | 2 | 0 data, 1 missing-clock mark, 2 checksum byte |
| wgate | output | 1 | Write gate |
| drq | output | 1 | Holding register is empty and a byte is requested |
| lost_data | output | 1 | A byte was missing when needed |
| busy | output | 1 | Operation in progress |
| intrq | output | 1 | End-of-operation interrupt |

## Verification
The assertions take for granted that host_wr never falls in the same cycle as cmd_start. If it did, drq could read low right after busy rises. They also take for granted that index_in is low when reset is released. The stimulus drives every input on the falling clock edge and issues one event per cycle. The only exception is the deliberate case of an index edge together with a byte slot. The main sweep feeds all 256 host values in one track, so every value, including the three command codes, passes through a byte slot.

// File: rtl/fmtw_pkg.sv
package fmtw_pkg;

  typedef enum logic [1:0] {
    TAG_DATA = 2'd0,
    TAG_MARK = 2'd1,
    TAG_CRC  = 2'd2
  } tag_e;

  typedef enum logic [1:0] {
    CRC_HOLD   = 2'd0,
    CRC_UPD    = 2'd1,
    CRC_PRESET = 2'd2
  } crc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WRITE = 2'd2
  } fmt_state_e;

  function automatic logic [15:0] crc16_step(input logic [15:0] c,
                                              input logic [7:0]  d,
                                              input logic [15:0] poly);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

endpackage

// File: rtl/fmtw_rst_sync.sv
module fmtw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fmtw_edge.sv
module fmtw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  assign rise = level_in & ~level_q;
endmodule

// File: rtl/fmtw_crc.sv
module fmtw_crc
  import fmtw_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter int          CRC_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  crc_op_e           op,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init) begin
      crc_d = CRC_INIT;
    end else begin
      case (op)
        CRC_UPD:    crc_d = crc16_step(crc_q, din, CRC_POLY);
        CRC_PRESET: crc_d = crc16_step(CRC_INIT, din, CRC_POLY);
        default:    crc_d = crc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_INIT;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/fmtw_decode.sv
module fmtw_decode
  import fmtw_pkg::*;
#(
  parameter int              BYTE_W     = 8,
  parameter int              CRC_W      = 16,
  parameter int              LEFT_W     = 2,
  parameter logic [BYTE_W-1:0] CODE_SYNC  = 8'hF5,
  parameter logic [BYTE_W-1:0] CODE_MARK2 = 8'hF6,
  parameter logic [BYTE_W-1:0] CODE_CRC   = 8'hF7,
  parameter logic [BYTE_W-1:0] SYNC_BYTE  = 8'hA1,
  parameter logic [BYTE_W-1:0] MARK2_BYTE = 8'hC2
) (
  input  logic              full,
  input  logic [BYTE_W-1:0] held,
  input  logic [LEFT_W-1:0] crc_left,
  input  logic [CRC_W-1:0]  crc,
  output logic [BYTE_W-1:0] emit_byte,
  output tag_e              emit_tag,
  output crc_op_e           emit_op,
  output logic              consume,
  output logic              starve,
  output logic [LEFT_W-1:0] crc_left_nxt
);
  localparam int CRC_BYTES = CRC_W / BYTE_W;

  always_comb begin
    emit_byte    = '0;
    emit_tag     = TAG_DATA;
    emit_op      = CRC_HOLD;
    consume      = 1'b0;
    starve       = 1'b0;
    crc_left_nxt = crc_left;
    if (crc_left != '0) begin
      emit_byte    = crc[(int'(crc_left) - 1) * BYTE_W +: BYTE_W];
      emit_tag     = TAG_CRC;
      crc_left_nxt = crc_left - 1'b1;
    end else if (!full) begin
      emit_op = CRC_UPD;
      starve  = 1'b1;
    end else begin
      consume = 1'b1;
      if (held == CODE_SYNC) begin
        emit_byte = SYNC_BYTE;
        emit_tag  = TAG_MARK;
        emit_op   = CRC_PRESET;
      end else if (held == CODE_MARK2) begin
        emit_byte = MARK2_BYTE;
        emit_tag  = TAG_MARK;
        emit_op   = CRC_UPD;
      end else if (held == CODE_CRC) begin
        emit_byte    = crc[(CRC_BYTES - 1) * BYTE_W +: BYTE_W];
        emit_tag     = TAG_CRC;
        crc_left_nxt = LEFT_W'(CRC_BYTES - 1);
      end else begin
        emit_byte = held;
        emit_op   = CRC_UPD;
      end
    end
  end
endmodule

// File: rtl/trackfmt_engine.sv
module trackfmt_engine
  import fmtw_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter int          CRC_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_data,
  input  logic              byte_tick,
  input  logic              index_in,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic [1:0]        out_tag,
  output logic              wgate,
  output logic              drq,
  output logic              lost_data,
  output logic              busy,
  output logic              intrq
);
  localparam int CRC_BYTES = CRC_W / BYTE_W;
  localparam int LEFT_W    = $clog2(CRC_BYTES + 1);

  logic rst_n_i;
  logic idx_rise;

  fmt_state_e        state_q, state_d;
  logic [BYTE_W-1:0] held_q, held_d;
  logic              full_q, full_d;
  logic              lost_q, lost_d;
  logic              intrq_q, intrq_d;
  logic              wgate_q, wgate_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              ov_q, ov_d;
  logic [BYTE_W-1:0] ob_q, ob_d;
  tag_e              ot_q, ot_d;

  logic              crc_init;
  crc_op_e           crc_op;
  logic [CRC_W-1:0]  crc_val;

  logic [BYTE_W-1:0] dec_byte;
  tag_e              dec_tag;
  crc_op_e           dec_op;
  logic              dec_consume, dec_starve;
  logic [LEFT_W-1:0] dec_left;

  fmtw_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  fmtw_edge u_idx (
    .clk(clk), .rst_n(rst_n_i), .level_in(index_in), .rise(idx_rise)
  );

  fmtw_crc #(
    .BYTE_W(BYTE_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)
  ) u_crc (
    .clk(clk), .rst_n(rst_n_i), .init(crc_init), .op(crc_op),
    .din(dec_byte), .crc(crc_val)
  );

  fmtw_decode #(
    .BYTE_W(BYTE_W), .CRC_W(CRC_W), .LEFT_W(LEFT_W)
  ) u_dec (
    .full(full_q), .held(held_q), .crc_left(left_q), .crc(crc_val),
    .emit_byte(dec_byte), .emit_tag(dec_tag), .emit_op(dec_op),
    .consume(dec_consume), .starve(dec_starve), .crc_left_nxt(dec_left)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    held_d   = held_q;
    full_d   = full_q;
    lost_d   = lost_q;
    intrq_d  = intrq_q;
    wgate_d  = wgate_q;
    left_d   = left_q;
    ov_d     = 1'b0;
    ob_d     = ob_q;
    ot_d     = ot_q;
    crc_init = 1'b0;
    crc_op   = CRC_HOLD;

    case (state_q)
      ST_IDLE: begin
        if (cmd_start) begin
          state_d  = ST_ARMED;
          full_d   = 1'b0;
          lost_d   = 1'b0;
          intrq_d  = 1'b0;
          left_d   = '0;
          crc_init = 1'b1;
        end
      end
      ST_ARMED: begin
        if (idx_rise) begin
          if (full_q) begin
            state_d = ST_WRITE;
          end else begin
            state_d = ST_IDLE;
            lost_d  = 1'b1;
            intrq_d = 1'b1;
          end
        end
      end
      ST_WRITE: begin
        if (idx_rise) begin
          state_d = ST_IDLE;
          intrq_d = 1'b1;
          wgate_d = 1'b0;
          left_d  = '0;
        end else if (byte_tick) begin
          ov_d    = 1'b1;
          ob_d    = dec_byte;
          ot_d    = dec_tag;
          wgate_d = 1'b1;
          left_d  = dec_left;
          crc_op  = dec_op;
          if (dec_consume) full_d = 1'b0;
          if (dec_starve)  lost_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (host_wr) begin
      held_d = host_data;
      full_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      held_q  <= '0;
      full_q  <= 1'b0;
      lost_q  <= 1'b0;
      intrq_q <= 1'b0;
      wgate_q <= 1'b0;
      left_q  <= '0;
      ov_q    <= 1'b0;
      ob_q    <= '0;
      ot_q    <= TAG_DATA;
    end else begin
      state_q <= state_d;
      held_q  <= held_d;
      full_q  <= full_d;
      lost_q  <= lost_d;
      intrq_q <= intrq_d;
      wgate_q <= wgate_d;
      left_q  <= left_d;
      ov_q    <= ov_d;
      ob_q    <= ob_d;
      ot_q    <= ot_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign drq       = busy & ~full_q;
  assign lost_data = lost_q;
  assign intrq     = intrq_q;
  assign wgate     = wgate_q;
  assign out_valid = ov_q;
  assign out_byte  = ob_q;
  assign out_tag   = ot_q;
endmodule

// File: rtl/fmtw_chk.sv
module fmtw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic [7:0] out_byte,
  input logic [1:0] out_tag,
  input logic       wgate,
  input logic       drq,
  input logic       busy,
  input logic       intrq
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !wgate));

  // R2
  start_drq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> drq);

  // R4
  end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> intrq);

  // R5
  emit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> wgate);

  // R7
  mark_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tag == 2'd1) |-> (out_byte == 8'hA1 || out_byte == 8'hC2));

  // R11
  gate_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wgate |-> busy);
endmodule

bind trackfmt_engine fmtw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_byte(out_byte),
  .out_tag(out_tag), .wgate(wgate), .drq(drq), .busy(busy), .intrq(intrq)
);

// File: tb/trackfmt_engine_test.sv
module trackfmt_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 1'b0, host_wr = 1'b0, byte_tick = 1'b0, index_in = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic       out_valid, wgate, drq, lost_data, busy, intrq;
  logic [7:0] out_byte;
  logic [1:0] out_tag;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] crc_m;

  always #4 clk = ~clk;

  trackfmt_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .host_wr(host_wr),
    .host_data(host_data), .byte_tick(byte_tick), .index_in(index_in),
    .out_valid(out_valid), .out_byte(out_byte), .out_tag(out_tag),
    .wgate(wgate), .drq(drq), .lost_data(lost_data), .busy(busy), .intrq(intrq)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[15] ^ d[7-i]) r = (r << 1) ^ 16'h1021;
      else                r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) cmd_start = 1'b1;
    @(negedge clk) cmd_start = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk) begin host_wr = 1'b1; host_data = v; end
    @(negedge clk) host_wr = 1'b0;
  endtask

  task automatic slot();
    @(negedge clk) byte_tick = 1'b1;
    @(negedge clk) byte_tick = 1'b0;
  endtask

  task automatic index_edge();
    @(negedge clk) index_in = 1'b1;
    @(negedge clk) index_in = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [7:0] b, input logic [1:0] t);
    chk({req, " valid"}, out_valid, 1'b1);
    chk({req, " byte"},  out_byte, b);
    chk({req, " tag"},   out_tag, t);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 drq", drq, 0); chk("R1 wgate", wgate, 0);
    chk("R1 intrq", intrq, 0); chk("R1 lost", lost_data, 0); chk("R1 valid", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 start
    pulse_start();
    chk("R2 busy", busy, 1); chk("R2 drq", drq, 1); chk("R2 lost", lost_data, 0);
    // R3 slot before writing produces nothing
    slot();
    chk("R3 no output when armed", out_valid, 0);
    // R4 index with empty register
    index_edge();
    chk("R4 busy", busy, 0); chk("R4 lost", lost_data, 1); chk("R4 intrq", intrq, 1);
    chk("R4 valid", out_valid, 0);

    // R2 restart clears flags
    pulse_start();
    chk("R2 lost cleared", lost_data, 0); chk("R2 intrq cleared", intrq, 0);
    load(8'h4E);
    chk("R3 drq after load", drq, 0);
    pulse_start();
    chk("R2 start while busy ignored", drq, 0);

    // R5 begin writing
    crc_m = 16'hFFFF;
    index_edge();
    chk("R5 busy", busy, 1); chk("R5 wgate before slot", wgate, 0);
    slot();
    expect_out("R5 first", 8'h4E, 2'd0);
    chk("R5 wgate", wgate, 1);
    chk("R12 drq", drq, 1);
    crc_m = ref_crc(crc_m, 8'h4E);

    for (int v = 0; v < 256; v++) begin
      load(v[7:0]);
      slot();
      if (v == 8'hF5) begin
        crc_m = ref_crc(16'hFFFF, 8'hA1);
        expect_out("R7", 8'hA1, 2'd1);
      end else if (v == 8'hF6) begin
        expect_out("R8", 8'hC2, 2'd1);
        crc_m = ref_crc(crc_m, 8'hC2);
      end else if (v == 8'hF7) begin
        expect_out("R9 high", crc_m[15:8], 2'd2);
        chk("R12 drq after crc code", drq, 1);
        slot();
        expect_out("R9 low", crc_m[7:0], 2'd2);
      end else begin
        expect_out("R6", v[7:0], 2'd0);
        crc_m = ref_crc(crc_m, v[7:0]);
      end
      chk("R12 drq", drq, 1);
      if (v == 8'h80) begin
        chk("R10 lost before starve", lost_data, 0);
        slot();
        expect_out("R10 zero fill", 8'h00, 2'd0);
        chk("R10 lost", lost_data, 1);
        chk("R10 still busy", busy, 1);
        crc_m = ref_crc(crc_m, 8'h00);
      end
    end

    // R9 checksum again after more data (shows CRC bytes did not alter it)
    load(8'hF7); slot();
    expect_out("R9 again high", crc_m[15:8], 2'd2);
    slot();
    expect_out("R9 again low", crc_m[7:0], 2'd2);

    // R11 end on index edge together with a slot
    load(8'h33);
    @(negedge clk) begin index_in = 1'b1; byte_tick = 1'b1; end
    @(negedge clk) begin index_in = 1'b0; byte_tick = 1'b0; end
    chk("R11 valid", out_valid, 0); chk("R11 busy", busy, 0);
    chk("R11 wgate", wgate, 0); chk("R11 drq", drq, 0); chk("R11 intrq", intrq, 1);
    slot();
    chk("R11 no output after end", out_valid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule